// File: doc/BRIEF.md
# Tight-Loop Fetch Suppression Controller

This block sits between an instruction fetch port and an instruction decoder. It keeps three 16-bit words of local storage. The first slot acts as the decode word. The other two slots form a short prefetch queue. In sequential operation it requests words from consecutive word addresses and presents one instruction at a time to the decoder, together with its extension word when the instruction is a decrement-and-branch. Each presented instruction is retired by an execute-complete pulse. When the branch retires it also reports its condition and the loop counter value it saw.

The block watches for a tight loop: a one-word loopable instruction followed directly by a decrement-and-branch whose displacement points back at it. When such a branch is taken, the block refetches only the loop instruction and the first branch word, and keeps the displacement it already holds. If the refetched word still qualifies, it enters loop mode. In loop mode it presents the loop instruction and the branch alternately from its own storage and issues no fetches at all.

Loop mode ends in one of four ways:
- the counter runs out or the branch condition comes true;
- a pending interrupt is accepted at a branch completion;
- tracing is enabled;
- reset is asserted.

A bus error on a replayed instruction leaves the captured loop in place.

Top module: `tight_loop_ctl`

## Requirements
- R1: While reset is asserted, loop_active is 0, no instruction is presented (ex_valid 0), and a fetch is requested at the reset address (default 0).
- R2: Outside loop mode, words are fetched from consecutive word addresses and presented in order. A word with bits [15:12]=0101 and bits [7:3]=11001 is a decrement-and-branch. It is presented only together with the following word, which carries the byte displacement on ex_ext.
- R3: Loop mode can only follow a retired branch that meets all of these: it is taken, its displacement is 0xFFFC, the instruction retired just before it was flagged loopable, and trace_en is 0. The branch is taken when br_cond is 0 and br_cnt is not 0. A displacement other than 0xFFFC, or a non-loopable predecessor, never leads to loop mode.
- R4: On entry, the loop word and the first branch word are each fetched exactly one more time and the displacement word is not refetched. loop_active rises while the refetched loop word is presented and qualified loopable.
- R5: While loop_active is 1, fetch_req is 0.
- R6: Loop mode ends when a branch retires not taken. This happens when the condition is true, or when the counter value is 0, so that its decrement wraps to 0xFFFF. The first fetch afterwards is at the word following the displacement word.
- R7: In loop mode a pending interrupt is accepted only when the branch retires, signalled by irq_take together with that ex_done, and never at a loop-instruction completion. Accepting it leaves loop mode, and a later qualifying pass can enter loop mode again.
- R8: With trace_en set, loop mode is not entered. If trace_en is set during loop mode, loop mode ends at the next completion and the instruction count is preserved.
- R9: A bus_err pulse during loop mode discards that completion. The same instruction is presented again, loop mode stays active, and no fetch is issued.
- R10: Asserting reset during loop mode clears loop_active and ex_valid at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Instruction word fetch request |
| fetch_addr | output | ADDR_W | Word address of the request |
| fetch_ack | input | 1 | Fetch accepted; data valid in the same cycle |
| fetch_data | input | 16 | Fetched instruction word |
| ex_valid | output | 1 | An instruction is presented to the decoder |
| ex_word | output | 16 | Presented instruction word |
| ex_ext | output | 16 | Displacement word when ex_branch is 1 |
| ex_branch | output | 1 | Presented word is a decrement-and-branch |
| ex_loopable | input | 1 | Decoder qualifier: ex_word is a one-word loopable form |
| ex_done | input | 1 | Presented instruction has completed execution |
| br_cond | input | 1 | Branch condition result at a branch completion |
| br_cnt | input | 16 | Loop counter value before decrement |
| irq_pend | input | 1 | Interrupt pending |
| trace_en | input | 1 | Trace enable |
| bus_err | input | 1 | Bus error on the current instruction's operand access |
| irq_take | output | 1 | Interrupt accepted at this completion |
| loop_active | output | 1 | Loop mode is active |

## Verification
The checker watches four things on every cycle:
- no fetch request is raised while loop mode is active;
- an interrupt is accepted in loop mode only with a retiring branch;
- loop mode never rises while tracing is on;
- a bus error leaves the presented word and loop mode unchanged.

It also confirms that entry always coincides with a qualified loop word on the decoder output. Other behaviour depends on a whole sequence and only the directed scenarios show it:
- exact refetch counts per address on entry;
- iteration counts for counter exhaustion and early condition exit;
- the resume address after exit;
- rejection of a wrong displacement or a non-loopable predecessor;
- re-entry after an interrupt.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    localparam int WORD_W = 16;
    localparam int SLOTS  = 3;

    typedef logic [WORD_W-1:0] word_t;

    // M_SEQ: sequential fetch, M_ARM: refetching the loop body, M_LOOP: replay
    typedef enum logic [1:0] {
        M_SEQ  = 2'd0,
        M_ARM  = 2'd1,
        M_LOOP = 2'd2
    } mode_e;
endpackage

// File: rtl/tlc_brdec.sv
// Recognises a decrement-and-branch word and computes its target word address.
module tlc_brdec
    import tlc_pkg::*;
#(
    parameter int    ADDR_W    = 16,
    parameter word_t BR_MASK   = 16'hF0F8,
    parameter word_t BR_MATCH  = 16'h50C8,
    parameter word_t LOOP_DISP = 16'hFFFC
) (
    input  word_t             op,
    input  word_t             ext,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              is_br,
    output logic              disp_ok,
    output logic [ADDR_W-1:0] target
);
    localparam logic [ADDR_W-1:0] ONE = 1;

    logic signed [WORD_W-1:0] half_off;
    logic [ADDR_W-1:0]        off_w;

    always_comb begin
        is_br    = (op & BR_MASK) == BR_MATCH;
        disp_ok  = ext == LOOP_DISP;
        half_off = signed'(ext) >>> 1;        // byte displacement to words
        off_w    = ADDR_W'(half_off);
        target   = op_addr + ONE + off_w;     // relative to the extension word
    end
endmodule

// File: rtl/tlc_taken.sv
// Branch outcome: loops while the condition is false and the counter does not wrap.
module tlc_taken #(
    parameter int CNT_W = 16
) (
    input  logic             is_br,
    input  logic             cond,
    input  logic [CNT_W-1:0] cnt,
    output logic             taken
);
    always_comb taken = is_br && !cond && (cnt != '0);
endmodule

// File: rtl/tight_loop_ctl.sv
module tight_loop_ctl
    import tlc_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                CNT_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter word_t             BR_MASK    = 16'hF0F8,
    parameter word_t             BR_MATCH   = 16'h50C8,
    parameter word_t             LOOP_DISP  = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic [15:0]       fetch_data,
    output logic              ex_valid,
    output logic [15:0]       ex_word,
    output logic [15:0]       ex_ext,
    output logic              ex_branch,
    input  logic              ex_loopable,
    input  logic              ex_done,
    input  logic              br_cond,
    input  logic [CNT_W-1:0]  br_cnt,
    input  logic              irq_pend,
    input  logic              trace_en,
    input  logic              bus_err,
    output logic              irq_take,
    output logic              loop_active
);
    localparam logic [ADDR_W-1:0] A_ONE   = 1;
    localparam logic [ADDR_W-1:0] A_TWO   = 2;
    localparam logic [ADDR_W-1:0] A_THREE = 3;

    typedef struct packed {
        mode_e                  mode;
        logic                   phase;   // loop mode: 0 loop word, 1 branch
        logic [SLOTS-1:0]       v;
        word_t [SLOTS-1:0]      slot;
        logic [ADDR_W-1:0]      head;    // address of slot 0
        logic [ADDR_W-1:0]      pc;      // next fetch address
        logic                   lp_prev; // last retired word was loopable
    } st_t;

    st_t s_q, s_d;

    logic              is_br, disp_ok, taken, done, redirect;
    logic [ADDR_W-1:0] target;
    logic              sel_hi;

    assign sel_hi = (s_q.mode == M_LOOP) && s_q.phase;
    assign ex_word = sel_hi ? s_q.slot[1] : s_q.slot[0];
    assign ex_ext  = sel_hi ? s_q.slot[2] : s_q.slot[1];

    tlc_brdec #(
        .ADDR_W(ADDR_W), .BR_MASK(BR_MASK), .BR_MATCH(BR_MATCH), .LOOP_DISP(LOOP_DISP)
    ) u_brdec (
        .op(ex_word), .ext(ex_ext), .op_addr(s_q.head),
        .is_br(is_br), .disp_ok(disp_ok), .target(target)
    );

    tlc_taken #(.CNT_W(CNT_W)) u_taken (
        .is_br(is_br), .cond(br_cond), .cnt(br_cnt), .taken(taken)
    );

    always_comb begin
        case (s_q.mode)
            M_SEQ:   ex_valid = s_q.v[0] && (!is_br || s_q.v[1]);
            M_LOOP:  ex_valid = 1'b1;
            default: ex_valid = 1'b0;
        endcase
    end

    assign ex_branch   = is_br;
    assign loop_active = s_q.mode == M_LOOP;
    assign fetch_req   = (s_q.mode != M_LOOP) && !(&s_q.v);
    assign fetch_addr  = s_q.pc;
    assign done        = ex_valid && ex_done && !bus_err;

    always_comb begin
        s_d      = s_q;
        irq_take = 1'b0;
        redirect = 1'b0;
        case (s_q.mode)
            M_SEQ: if (done) begin
                irq_take = irq_pend;
                if (!is_br) begin
                    s_d.slot[0] = s_q.slot[1];
                    s_d.slot[1] = s_q.slot[2];
                    s_d.v       = {1'b0, s_q.v[SLOTS-1:1]};
                    s_d.head    = s_q.head + A_ONE;
                    s_d.lp_prev = ex_loopable;
                end else if (taken) begin
                    redirect    = 1'b1;
                    s_d.head    = target;
                    s_d.pc      = target;
                    s_d.lp_prev = 1'b0;
                    if (disp_ok && s_q.lp_prev && !trace_en) begin
                        s_d.mode    = M_ARM;
                        s_d.v       = 3'b100;       // keep displacement word
                        s_d.slot[2] = s_q.slot[1];
                    end else begin
                        s_d.v = '0;
                    end
                end else begin
                    s_d.slot[0] = s_q.slot[2];
                    s_d.v       = {2'b00, s_q.v[SLOTS-1]};
                    s_d.head    = s_q.head + A_TWO;
                    s_d.lp_prev = 1'b0;
                end
            end
            M_ARM: if (&s_q.v) begin
                s_d.pc    = s_q.head + A_THREE;
                s_d.phase = 1'b0;
                s_d.mode  = (ex_loopable && !trace_en) ? M_LOOP : M_SEQ;
            end
            M_LOOP: if (done) begin
                if (!s_q.phase) begin
                    if (trace_en) begin
                        s_d.mode    = M_SEQ;
                        s_d.slot[0] = s_q.slot[1];
                        s_d.slot[1] = s_q.slot[2];
                        s_d.v       = 3'b011;
                        s_d.head    = s_q.head + A_ONE;
                        s_d.lp_prev = 1'b0;
                    end else begin
                        s_d.phase = 1'b1;
                    end
                end else if (!taken) begin
                    s_d.mode    = M_SEQ;
                    s_d.phase   = 1'b0;
                    s_d.v       = '0;
                    s_d.head    = s_q.head + A_THREE;
                    s_d.lp_prev = 1'b0;
                end else if (irq_pend || trace_en) begin
                    irq_take    = irq_pend;
                    s_d.mode    = M_SEQ;
                    s_d.phase   = 1'b0;
                    s_d.lp_prev = 1'b0;
                end else begin
                    s_d.phase = 1'b0;
                end
            end
            default: s_d.mode = M_SEQ;
        endcase

        if (fetch_req && fetch_ack && !redirect) begin
            if (!s_d.v[0]) begin
                s_d.slot[0] = fetch_data;
                s_d.v[0]    = 1'b1;
            end else if (!s_d.v[1]) begin
                s_d.slot[1] = fetch_data;
                s_d.v[1]    = 1'b1;
            end else begin
                s_d.slot[2] = fetch_data;
                s_d.v[2]    = 1'b1;
            end
            s_d.pc = s_d.pc + A_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode    <= M_SEQ;
            s_q.phase   <= 1'b0;
            s_q.v       <= '0;
            s_q.slot    <= '0;
            s_q.head    <= RESET_ADDR;
            s_q.pc      <= RESET_ADDR;
            s_q.lp_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_req,
    input logic        ex_valid,
    input logic [15:0] ex_word,
    input logic        ex_branch,
    input logic        ex_loopable,
    input logic        ex_done,
    input logic        irq_pend,
    input logic        irq_take,
    input logic        trace_en,
    input logic        bus_err,
    input logic        loop_active
);
    a_r5_no_fetch_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> !fetch_req);

    a_r7_take_at_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && irq_take) |-> ex_branch);

    a_r7_take_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (ex_done && irq_pend));

    a_r8_trace_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en |=> !$rose(loop_active));

    a_r9_berr_holds_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && bus_err) |=> (loop_active && $stable(ex_word)));

    a_r4_entry_on_loop_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_active) |-> (ex_valid && !ex_branch && ex_loopable));
endmodule

bind tight_loop_ctl tlc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .ex_valid(ex_valid),
    .ex_word(ex_word), .ex_branch(ex_branch), .ex_loopable(ex_loopable),
    .ex_done(ex_done), .irq_pend(irq_pend), .irq_take(irq_take),
    .trace_en(trace_en), .bus_err(bus_err), .loop_active(loop_active)
);

// File: tb/sim_tight_loop_ctl.sv
`timescale 1ns/1ps
module sim_tight_loop_ctl;
    localparam logic [15:0] W_NOP  = 16'h4E71;
    localparam logic [15:0] W_MOVE = 16'h3290;
    localparam logic [15:0] W_BR   = 16'h51C8;
    localparam logic [15:0] W_END  = 16'h4AFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req, fetch_ack;
    logic [15:0] fetch_addr, fetch_data;
    logic        ex_valid, ex_branch, ex_loopable;
    logic [15:0] ex_word, ex_ext;
    logic        ex_done = 1'b0, br_cond = 1'b0, irq_pend = 1'b0;
    logic        trace_en = 1'b0, bus_err = 1'b0;
    logic [15:0] br_cnt = '0;
    logic        irq_take, loop_active;

    logic [15:0] mem [16];
    assign fetch_ack   = 1'b1;
    assign fetch_data  = mem[fetch_addr[3:0]];
    assign ex_loopable = ex_word[15:12] == 4'h3;

    always #2 clk = ~clk;

    tight_loop_ctl u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .ex_valid(ex_valid),
        .ex_word(ex_word), .ex_ext(ex_ext), .ex_branch(ex_branch),
        .ex_loopable(ex_loopable), .ex_done(ex_done), .br_cond(br_cond),
        .br_cnt(br_cnt), .irq_pend(irq_pend), .trace_en(trace_en),
        .bus_err(bus_err), .irq_take(irq_take), .loop_active(loop_active)
    );

    int n_chk = 0, n_bad = 0;
    int nbr, nmv, nfl, nrise, nirq, irq_bad, ext_bad, exit_addr, cond_at;
    int fcount [16];
    logic [15:0] cnt_m, disp_m;
    logic run, irq_arm, irq_clr, berr_arm, berr_follow, trace_arm;
    logic la_prev, after_exit, ended;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of the execution-unit model and monitor
    task automatic step();
        @(negedge clk);
        if (irq_clr) begin irq_pend = 1'b0; irq_clr = 1'b0; end
        ex_done = 1'b0; bus_err = 1'b0; br_cond = 1'b0; br_cnt = cnt_m;
        if (trace_arm && loop_active) begin trace_en = 1'b1; trace_arm = 1'b0; end
        if (run && ex_valid && ex_word != W_END) begin
            ex_done = 1'b1;
            if (ex_branch) br_cond = (nbr == cond_at);
            if (irq_arm && loop_active && !ex_branch) begin irq_pend = 1'b1; irq_arm = 1'b0; end
            if (berr_arm && loop_active && !ex_branch) begin bus_err = 1'b1; berr_arm = 1'b0; end
        end
        #1;
        if (berr_follow) begin
            chk("R9 same word re-presented in loop after bus error",
                int'(ex_valid && ex_word == W_MOVE && loop_active), 1);
            berr_follow = 1'b0;
        end
        if (bus_err) berr_follow = 1'b1;
        if (loop_active && !la_prev) nrise++;
        if (!loop_active && la_prev) after_exit = 1'b1;
        la_prev = loop_active;
        if (fetch_req && fetch_ack) begin
            fcount[fetch_addr[3:0]]++;
            if (loop_active) nfl++;
            if (after_exit) begin exit_addr = int'(fetch_addr); after_exit = 1'b0; end
        end
        if (ex_done && !bus_err) begin
            if (ex_branch) begin
                if (ex_ext != disp_m) ext_bad++;
                if (!br_cond) cnt_m = cnt_m - 16'd1;
                nbr++;
            end else if (ex_word == W_MOVE) begin
                nmv++;
            end
        end
        if (irq_take) begin
            nirq++;
            if (!ex_branch) irq_bad++;
            irq_clr = 1'b1;
        end
        ended = ex_valid && ex_word == W_END;
    endtask

    // program: nop nop <w2> branch <disp> nop nop nop end
    task automatic setup(input logic [15:0] w2, input logic [15:0] disp,
                         input logic [15:0] cnt, input int cond_idx);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin mem[i] = W_NOP; fcount[i] = 0; end
        mem[2] = w2; mem[3] = W_BR; mem[4] = disp; mem[8] = W_END;
        disp_m = disp; cnt_m = cnt; cond_at = cond_idx;
        nbr = 0; nmv = 0; nfl = 0; nrise = 0; nirq = 0; irq_bad = 0; ext_bad = 0;
        exit_addr = -1; run = 1'b0; irq_arm = 1'b0; irq_clr = 1'b0;
        berr_arm = 1'b0; berr_follow = 1'b0; trace_arm = 1'b0;
        la_prev = 1'b0; after_exit = 1'b0; ended = 1'b0;
        ex_done = 1'b0; bus_err = 1'b0; br_cond = 1'b0; irq_pend = 1'b0; trace_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_end(input string req);
        run = 1'b1;
        for (int i = 0; i < 3000 && !ended; i++) step();
        run = 1'b0;
        chk({req, " program reached end marker"}, int'(ended), 1);
    endtask

    task automatic t_reset();
        setup(W_MOVE, 16'hFFFC, 16'd4, -1);
        rst_n = 1'b0;
        #1;
        chk("R1 loop_active in reset", int'(loop_active), 0);
        chk("R1 ex_valid in reset", int'(ex_valid), 0);
        chk("R1 fetch_req in reset", int'(fetch_req), 1);
        chk("R1 fetch_addr in reset", int'(fetch_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_count_exit();
        setup(W_MOVE, 16'hFFFC, 16'd4, -1);
        run_to_end("R6");
        chk("R2 branch extension word equals displacement", ext_bad, 0);
        chk("R3 loop entered once", nrise, 1);
        chk("R4 loop word fetched twice", fcount[2], 2);
        chk("R4 branch word fetched twice", fcount[3], 2);
        chk("R4 displacement fetched once", fcount[4], 1);
        chk("R5 fetches while looping", nfl, 0);
        chk("R6 loop body executions on count exhaustion", nmv, 5);
        chk("R6 branch executions on count exhaustion", nbr, 5);
        chk("R6 first fetch after exit", exit_addr, 5);
        chk("R6 loop inactive at end", int'(loop_active), 0);
    endtask

    task automatic t_cond_exit();
        setup(W_MOVE, 16'hFFFC, 16'd100, 2);
        run_to_end("R6");
        chk("R6 branch executions on condition exit", nbr, 3);
        chk("R6 loop body executions on condition exit", nmv, 3);
        chk("R6 entered before condition exit", nrise, 1);
    endtask

    task automatic t_bad_disp();
        setup(W_MOVE, 16'hFFFA, 16'd2, -1);
        run_to_end("R3");
        chk("R3 no entry with displacement 0xFFFA", nrise, 0);
        chk("R3 branch executions with displacement 0xFFFA", nbr, 3);
    endtask

    task automatic t_bad_pred();
        setup(W_NOP, 16'hFFFC, 16'd2, -1);
        run_to_end("R3");
        chk("R3 no entry with non-loopable predecessor", nrise, 0);
        chk("R3 branch executions with non-loopable predecessor", nbr, 3);
    endtask

    task automatic t_trace_block();
        setup(W_MOVE, 16'hFFFC, 16'd3, -1);
        trace_en = 1'b1;
        run_to_end("R8");
        chk("R8 no entry with trace set", nrise, 0);
        chk("R8 branch executions with trace set", nbr, 4);
    endtask

    task automatic t_trace_exit();
        setup(W_MOVE, 16'hFFFC, 16'd4, -1);
        trace_arm = 1'b1;
        run_to_end("R8");
        chk("R8 entered once before trace exit", nrise, 1);
        chk("R8 loop body executions across trace exit", nmv, 5);
        chk("R8 branch executions across trace exit", nbr, 5);
    endtask

    task automatic t_irq();
        setup(W_MOVE, 16'hFFFC, 16'd6, -1);
        irq_arm = 1'b1;
        run_to_end("R7");
        chk("R7 interrupts accepted", nirq, 1);
        chk("R7 interrupt taken at loop body completion", irq_bad, 0);
        chk("R7 loop re-entered after interrupt exit", nrise, 2);
        chk("R7 branch executions across interrupt", nbr, 7);
        chk("R7 loop body executions across interrupt", nmv, 7);
    endtask

    task automatic t_berr();
        setup(W_MOVE, 16'hFFFC, 16'd4, -1);
        berr_arm = 1'b1;
        run_to_end("R9");
        chk("R9 loop entered once despite bus error", nrise, 1);
        chk("R9 fetches while looping", nfl, 0);
        chk("R9 loop word not refetched", fcount[2], 2);
        chk("R9 completed loop body executions", nmv, 5);
    endtask

    task automatic t_reset_in_loop();
        setup(W_MOVE, 16'hFFFC, 16'd50, -1);
        run = 1'b1;
        for (int i = 0; i < 200 && !loop_active; i++) step();
        chk("R10 loop reached before reset", int'(loop_active), 1);
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        ex_done = 1'b0;
        #1;
        chk("R10 loop_active cleared by reset", int'(loop_active), 0);
        chk("R10 ex_valid cleared by reset", int'(ex_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_count_exit();
        t_cond_exit();
        t_bad_disp();
        t_bad_pred();
        t_trace_block();
        t_trace_exit();
        t_irq();
        t_berr();
        t_reset_in_loop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule